// File: doc/BRIEF.md
# Sub-Second Alarm Reload Timer

This block produces a periodic alarm from the sub-second tick of a real-time clock. A 16-bit reload register holds the alarm interval. Software writes a control word that enables the alarm. The enable write loads a down-counter from the reload register. While the alarm runs, the counter steps down once per tick. When a tick arrives with the counter at zero, the counter takes the reload value again and a sticky alarm flag is raised. With a reload value of N, the alarm therefore repeats every N+1 ticks.

Software reads the reload value, the enable bit, the flag and the live count at any time. The reload register is protected while the timer is in use. A write to it takes effect only if the alarm is disabled and the RTC busy input is low. The flag stays set until software clears it through the control write port. Disabling the alarm freezes the counter at its current value.

The control path is a two-state machine. In `ST_IDLE` the alarm is disabled and the counter holds. The transition `IDLE->RUN` fires on a control write with the enable bit at 1, and it loads the counter. In `ST_RUN` the counter counts ticks and auto-reloads. The transition `RUN->IDLE` fires on a control write with the enable bit at 0. A control write that asks for the state the machine is already in leaves the state unchanged. This self-loop is `RUN->RUN` when re-enabling and `IDLE->IDLE` when disabling again.

Top module: `subsec_alarm_timer`

## Requirements
- R1: After reset the reload value is 0, the alarm is disabled, the flag is 0 and the count is 0.
- R2: A control write with the enable bit at 1 while the alarm is disabled enables the alarm. From the next cycle the count equals the reload value that was held before that write.
- R3: A reload write changes the reload value only when, in that cycle, the alarm is disabled and `rtc_busy` is 0. Any other reload write is ignored.
- R4: While the alarm is enabled, each tick does one of two things. If the count is nonzero, the count drops by 1. If the count is zero, the count takes the reload value and the flag is set. The flag therefore rises every reload+1 ticks.
- R5: With a reload value of 0 the count stays 0 and every tick is an expiry.
- R6: The flag stays set until a control write carries flag bit 0. A control write with flag bit 1 leaves the flag as it is. If an expiry and a clear fall in the same cycle, the flag ends up set.
- R7: Disabling the alarm with a control write (enable bit 0) stops the counter. The count then holds through ticks, and the disable leaves the flag unchanged.
- R8: The reload value is readable at the read port in every state, including while the alarm runs.
- R9: A control write with the enable bit at 1 while the alarm is already enabled does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle sub-second tick pulse |
| rtc_busy | input | 1 | RTC busy; blocks reload writes when 1 |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | 16 | Reload write data |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_en_wdata | input | 1 | Enable bit written by a control write |
| ctrl_flag_wdata | input | 1 | Flag bit written; 0 clears, 1 keeps |
| reload_rdata | output | 16 | Current reload value |
| alarm_en | output | 1 | Alarm enabled (state is ST_RUN) |
| alarm_flag | output | 1 | Sticky alarm flag |
| count_value | output | 16 | Current down-counter value |

## Verification
The assertions check several rules in every cycle:
- the reload lock and write acceptance;
- that every expiry reloads the counter and sets the flag;
- that the counter holds while idle;
- the set-over-clear priority of the flag;
- that each enable write loads the counter and enters `ST_RUN`.

Some properties are visible only across many cycles, so only the bench's scenarios can show them:
- the N+1-tick alarm period;
- the tick-by-tick behaviour with a zero reload;
- that a re-enable while running leaves the count untouched;
- that a disable followed by a re-enable restarts from the reload value rather than from the frozen count.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ssa_state_e;
endpackage

// File: rtl/ssa_reload_reg.sv
module ssa_reload_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         en_i,
    input  logic         busy_i,
    output logic [W-1:0] q_o
);
    logic         accept;
    logic [W-1:0] q_q;

    assign accept = we_i && !en_i && !busy_i;

    always_ff @(posedge clk) begin
        if (!rst_n)
            q_q <= '0;
        else if (accept)
            q_q <= wdata_i;
    end

    assign q_o = q_q;

    // R3: a blocked write leaves the register untouched
    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (en_i || busy_i)) |=> $stable(q_o));
    // R3: an unblocked write lands
    p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !en_i && !busy_i) |=> (q_o == $past(wdata_i)));
endmodule

// File: rtl/ssa_ctrl_fsm.sv
module ssa_ctrl_fsm
    import ssa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_we_i,
    input  logic en_wdata_i,
    output logic load_o,
    output logic run_o
);
    ssa_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctrl_we_i && en_wdata_i)  state_d = ST_RUN;
            ST_RUN:  if (ctrl_we_i && !en_wdata_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        load_o = 1'b0;
        run_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = ctrl_we_i && en_wdata_i;
            ST_RUN:  run_o  = 1'b1;
            default: ;
        endcase
    end

    // R2: an enable write from idle always ends in the running state
    p_start_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> run_o);
    // R7: a disable write always ends in idle
    p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we_i && !en_wdata_i) |=> !run_o);
endmodule

// File: rtl/ssa_down_counter.sv
module ssa_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] count_o,
    output logic         expire_o
);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] count_q;
    logic         at_zero;

    assign at_zero  = (count_q == ZERO);
    assign expire_o = run_i && tick_i && at_zero;

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= ZERO;
        else if (load_i)
            count_q <= reload_i;
        else if (run_i && tick_i)
            count_q <= at_zero ? reload_i : count_q - 1'b1;
    end

    assign count_o = count_q;

    // R2: start load takes the reload value
    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(reload_i)));
    // R4: expiry reloads the counter
    p_expire_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (count_o == $past(reload_i)));
    // R4: nonzero tick steps down by one
    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && count_o != ZERO) |=> (count_o == $past(count_o) - 1'b1));
    // R7: idle counter holds
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(count_o));
endmodule

// File: rtl/ssa_sticky_flag.sv
module ssa_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R6: set has priority over clear
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R6: clear alone empties the flag
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    // R6: no event, no change
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/subsec_alarm_timer.sv
module subsec_alarm_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rtc_busy,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_wdata,
    input  logic             ctrl_we,
    input  logic             ctrl_en_wdata,
    input  logic             ctrl_flag_wdata,
    output logic [CNT_W-1:0] reload_rdata,
    output logic             alarm_en,
    output logic             alarm_flag,
    output logic [CNT_W-1:0] count_value
);
    logic             load;
    logic             run;
    logic             expire;
    logic             flag_clr;
    logic [CNT_W-1:0] reload_q;

    assign flag_clr = ctrl_we && !ctrl_flag_wdata;

    ssa_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we_i  (ctrl_we),
        .en_wdata_i (ctrl_en_wdata),
        .load_o     (load),
        .run_o      (run)
    );

    ssa_reload_reg #(.W(CNT_W)) u_reload (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reload_we),
        .wdata_i (reload_wdata),
        .en_i    (run),
        .busy_i  (rtc_busy),
        .q_o     (reload_q)
    );

    ssa_down_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .run_i    (run),
        .tick_i   (tick),
        .reload_i (reload_q),
        .count_o  (count_value),
        .expire_o (expire)
    );

    ssa_sticky_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (expire),
        .clr_i  (flag_clr),
        .flag_o (alarm_flag)
    );

    assign reload_rdata = reload_q;
    assign alarm_en     = run;

    // R9: re-enable while running does not disturb the count
    p_no_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctrl_we && ctrl_en_wdata && !tick) |=> $stable(count_value));
endmodule

// File: tb/tb_subsec_alarm_timer.sv
`timescale 1ns/1ps
module tb_subsec_alarm_timer;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         rtc_busy = 1'b0;
    logic         reload_we = 1'b0;
    logic [W-1:0] reload_wdata = '0;
    logic         ctrl_we = 1'b0;
    logic         ctrl_en_wdata = 1'b0;
    logic         ctrl_flag_wdata = 1'b1;
    logic [W-1:0] reload_rdata;
    logic         alarm_en;
    logic         alarm_flag;
    logic [W-1:0] count_value;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0] m_reload = '0;
    logic [W-1:0] m_count = '0;
    logic         m_en = 1'b0;
    logic         m_flag = 1'b0;

    always #2 clk = ~clk;

    subsec_alarm_timer #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rtc_busy(rtc_busy),
        .reload_we(reload_we), .reload_wdata(reload_wdata),
        .ctrl_we(ctrl_we), .ctrl_en_wdata(ctrl_en_wdata),
        .ctrl_flag_wdata(ctrl_flag_wdata),
        .reload_rdata(reload_rdata), .alarm_en(alarm_en),
        .alarm_flag(alarm_flag), .count_value(count_value)
    );

    function automatic logic [W-1:0] f_next_count(logic [W-1:0] c, logic [W-1:0] rl,
                                                  logic en, logic tk, logic ld);
        if (ld) return rl;
        if (en && tk) return (c == '0) ? rl : c - 1'b1;
        return c;
    endfunction

    function automatic logic f_next_flag(logic f, logic ex, logic cl);
        if (ex) return 1'b1;
        if (cl) return 1'b0;
        return f;
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(string tag);
        chk({tag, " reload R8"}, reload_rdata, m_reload);
        chk({tag, " enable R2"}, W'(alarm_en), W'(m_en));
        chk({tag, " flag R6"}, W'(alarm_flag), W'(m_flag));
        chk({tag, " count R4"}, count_value, m_count);
    endtask

    // Drive one cycle at the falling edge, advance the model, compare after the rising edge.
    task automatic step(logic cwe, logic cen, logic cfl, logic rwe,
                        logic [W-1:0] rwd, logic bsy, logic tk, string tag);
        logic ld, ex;
        @(negedge clk);
        ctrl_we = cwe; ctrl_en_wdata = cen; ctrl_flag_wdata = cfl;
        reload_we = rwe; reload_wdata = rwd; rtc_busy = bsy; tick = tk;
        ld = cwe && cen && !m_en;
        ex = m_en && tk && (m_count == '0);
        @(posedge clk);
        m_count = f_next_count(m_count, m_reload, m_en, tk, ld);
        m_flag  = f_next_flag(m_flag, ex, cwe && !cfl);
        if (rwe && !m_en && !bsy) m_reload = rwd;
        if (cwe) m_en = cen;
        #1;
        compare_all(tag);
    endtask

    task automatic idle_tick(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 1, 0, '0, 0, 1, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0;
        // R1: reset state
        chk("R1 reload", reload_rdata, '0);
        chk("R1 enable", W'(alarm_en), '0);
        chk("R1 flag", W'(alarm_flag), '0);
        chk("R1 count", count_value, '0);

        // R3: busy blocks the write
        step(0, 0, 1, 1, 16'd3, 1, 0, "R3 busy");
        chk("R3 busy-blocked", reload_rdata, 16'd0);
        step(0, 0, 1, 1, 16'd3, 0, 0, "R3 accept");
        chk("R8 readback", reload_rdata, 16'd3);

        // R2: enable loads
        step(1, 1, 1, 0, '0, 0, 0, "R2 enable");
        chk("R2 loaded count", count_value, 16'd3);
        // R3: enabled blocks the write
        step(0, 0, 1, 1, 16'd7, 0, 0, "R3 enabled");
        chk("R3 enabled-blocked", reload_rdata, 16'd3);

        // R4: period of reload+1 ticks
        step(0, 0, 1, 0, '0, 0, 1, "R4"); step(0, 0, 1, 0, '0, 0, 1, "R4");
        step(0, 0, 1, 0, '0, 0, 1, "R4");
        chk("R4 at zero", count_value, 16'd0);
        chk("R4 no flag yet", W'(alarm_flag), 16'd0);
        step(0, 0, 1, 0, '0, 0, 1, "R4");
        chk("R4 reload", count_value, 16'd3);
        chk("R4 flag set", W'(alarm_flag), 16'd1);

        // R9: re-enable while running
        step(1, 1, 1, 0, '0, 0, 0, "R9");
        chk("R9 no reload", count_value, 16'd3);
        chk("R6 flag kept by write 1", W'(alarm_flag), 16'd1);
        step(1, 1, 0, 0, '0, 0, 0, "R6 clr");
        chk("R6 cleared", W'(alarm_flag), 16'd0);

        // R6: set wins over a clear in the same cycle
        step(0, 0, 1, 0, '0, 0, 1, "R6"); step(0, 0, 1, 0, '0, 0, 1, "R6");
        step(0, 0, 1, 0, '0, 0, 1, "R6");
        step(1, 1, 0, 0, '0, 0, 1, "R6 race");
        chk("R6 set wins", W'(alarm_flag), 16'd1);

        // R7: disable holds count and flag
        step(0, 0, 1, 0, '0, 0, 1, "R7");
        step(1, 0, 1, 0, '0, 0, 1, "R7 disable");
        chk("R7 count held", count_value, 16'd1);
        chk("R7 flag kept", W'(alarm_flag), 16'd1);
        idle_tick(4, "R7 idle");
        chk("R7 still held", count_value, 16'd1);

        // R5: zero reload expires every tick
        step(1, 0, 0, 1, 16'd0, 0, 0, "R5 setup");
        step(1, 1, 1, 0, '0, 0, 0, "R5 enable");
        for (int i = 0; i < 4; i++) begin
            step(1, 1, 0, 0, '0, 0, 0, "R5 clr");
            chk("R5 flag cleared", W'(alarm_flag), 16'd0);
            step(0, 0, 1, 0, '0, 0, 1, "R5 tick");
            chk("R5 flag every tick", W'(alarm_flag), 16'd1);
            chk("R5 count zero", count_value, 16'd0);
        end
        step(1, 0, 1, 0, '0, 0, 0, "R7 off");

        // Random phase, fixed seed
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 3000; i++) begin
            logic cwe, cen, cfl, rwe, bsy, tk;
            logic [W-1:0] rwd;
            cwe = ($urandom_range(0, 9) == 0);
            cen = ($urandom_range(0, 3) != 0);
            cfl = $urandom_range(0, 1);
            rwe = ($urandom_range(0, 4) == 0);
            bsy = ($urandom_range(0, 3) == 0);
            tk  = $urandom_range(0, 1);
            rwd = W'($urandom_range(0, 12));
            step(cwe, cen, cfl, rwe, rwd, bsy, tk, "rand R3 R4 R6");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule